// File: doc/BRIEF.md
# Direction-Qualified Position Compare Event Unit

This block watches the live position of a rotary encoder, given as a phase count within one revolution and a revolution (index) count, and raises a sticky compare event when that position reaches a programmed target. The target can require a particular direction of rotation, or accept either direction. It can also drop the revolution term so that only the phase count is compared, which gives one match per revolution.

The compare event shares a four-bit sticky event register with three event pulses that neighbouring logic produces: watchdog timeout, home and index. Software clears any event bit by writing a 1 to it. An interrupt line is raised from the event register through a per-bit interrupt enable. A one-cycle trigger pulse follows any newly detected event whose trigger enable is set. The counters that produce the position are outside this block.

Top module: `poscmp_unit`

## Requirements
- R1: After reset the event register reads 0, `irq` is low and `trg` is low.
- R2: When the compare condition becomes true, event bit 1 is set one clock later. The condition is: `phase_cnt` equals `phase_cmp`, the revolution term holds, and the direction term holds.
- R3: With `z_cmp_dis` low, the revolution term needs `z_cnt` equal to `z_cmp`. With `z_cmp_dis` high, `z_cnt` has no effect on the match.
- R4: With `dir_ignore` low, the direction term needs `dir_neg` equal to `dir_sel` (0 = positive rotation, 1 = negative rotation). With `dir_ignore` high, `dir_neg` has no effect.
- R5: A match is detected only on the cycle in which the condition goes from false to true. A condition that stays true does not set bit 1 again after it has been cleared.
- R6: A cycle with `clr_wr` high clears each event bit whose `clr_mask` bit is 1 and leaves the bits whose mask bit is 0 unchanged.
- R7: An event that is detected in the same cycle as a clear of its bit leaves that bit set.
- R8: `irq` is high exactly when some event bit and its `irq_en` bit are both 1. This is visible in the same cycle as the event register.
- R9: `trg` is high for one cycle, together with the update of the event register, when a newly detected event has its `trg_en` bit set. Otherwise it is low.
- R10: Event bit positions: 3 = watchdog (`wdog_evt`), 2 = home (`home_evt`), 1 = position compare, 0 = index (`zidx_evt`). An input pulse sets its bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_cnt | input | PH_W | Live phase count |
| z_cnt | input | Z_W | Live revolution count |
| dir_neg | input | 1 | Current rotation direction, 1 = negative |
| phase_cmp | input | PH_W | Phase compare target |
| z_cmp | input | Z_W | Revolution compare target |
| z_cmp_dis | input | 1 | Leave the revolution term out of the match |
| dir_sel | input | 1 | Required direction, 0 = positive, 1 = negative |
| dir_ignore | input | 1 | Match in either direction |
| wdog_evt | input | 1 | Watchdog timeout event pulse |
| home_evt | input | 1 | Home event pulse |
| zidx_evt | input | 1 | Index event pulse |
| clr_wr | input | 1 | Write strobe for write-1-to-clear |
| clr_mask | input | 4 | Bits to clear |
| irq_en | input | 4 | Interrupt enables per event bit |
| trg_en | input | 4 | Trigger enables per event bit |
| flags | output | 4 | Sticky event register |
| irq | output | 1 | Interrupt request |
| trg | output | 1 | Trigger pulse |

## Verification
The hardest case to reach is a match that arrives in the very cycle a clear of the same bit is written, while the position keeps sitting on the target. The edge detector must fire once and then stay silent, while the clear must lose to the set. Directed sequences first move the position away from the target, then step it back onto the target together with a clear write, and then hold it there while clearing again. Random cycles keep the position within one step of the target, so rising and held conditions occur often under all qualifier settings.

// File: rtl/poscmp_pkg.sv
package poscmp_pkg;
  localparam int unsigned NEV     = 4;
  localparam int unsigned EV_ZIDX = 0;
  localparam int unsigned EV_CMP  = 1;
  localparam int unsigned EV_HOME = 2;
  localparam int unsigned EV_WDOG = 3;

  // direction qualifier: pass when ignored or when the sense agrees
  function automatic logic dir_ok(input logic neg, input logic want, input logic ign);
    return ign | ~(neg ^ want);
  endfunction

  // revolution qualifier as a width-independent pre-compared bit
  function automatic logic rev_ok(input logic eq, input logic dis);
    return dis | eq;
  endfunction
endpackage

// File: rtl/poscmp_match.sv
module poscmp_match
  import poscmp_pkg::*;
#(
  parameter int unsigned PH_W = 16,
  parameter int unsigned Z_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_cnt,
  input  logic [Z_W-1:0]  z_cnt,
  input  logic            dir_neg,
  input  logic [PH_W-1:0] phase_cmp,
  input  logic [Z_W-1:0]  z_cmp,
  input  logic            z_cmp_dis,
  input  logic            dir_sel,
  input  logic            dir_ignore,
  output logic            cond,
  output logic            hit
);
  logic ph_eq, z_eq, cond_q;

  assign ph_eq = (phase_cnt == phase_cmp);
  assign z_eq  = (z_cnt == z_cmp);
  assign cond  = ph_eq & rev_ok(z_eq, z_cmp_dis) & dir_ok(dir_neg, dir_sel, dir_ignore);

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign hit = cond & ~cond_q;

  // R5: two consecutive true conditions never produce a second hit
  a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && $past(cond)) |-> !hit);
  // R3: a revolution mismatch without the disable never hits
  a_r3_rev_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!z_cmp_dis && (z_cnt != z_cmp)) |-> !hit);
  // R4: a direction mismatch without the ignore bit never hits
  a_r4_dir_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_ignore && (dir_neg != dir_sel)) |-> !hit);
endmodule

// File: rtl/poscmp_flags.sv
module poscmp_flags
  import poscmp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           clr_wr,
  input  logic [NEV-1:0] clr_mask,
  input  logic [NEV-1:0] irq_en,
  input  logic [NEV-1:0] trg_en,
  output logic [NEV-1:0] flags,
  output logic           irq,
  output logic           trg
);
  logic [NEV-1:0] clr_v;
  assign clr_v = clr_mask & {NEV{clr_wr}};

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr_v[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trg <= 1'b0;
    else        trg <= |(evt & trg_en);
  end

  assign irq = |(flags & irq_en);

  // R7: an event always leaves its bit set, clear or not
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_CMP] |=> flags[EV_CMP]);
  // R6: a clear without a new event empties the bit
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[EV_CMP] && !evt[EV_CMP]) |=> !flags[EV_CMP]);
  // R6: a bit not cleared and not hit holds its value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(clr_wr && clr_mask[EV_CMP]) && !evt[EV_CMP]) |=> $stable(flags[EV_CMP]));
  // R9: a trigger pulse needs an enabled event one cycle before
  a_r9_trg_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trg |-> $past(|(evt & trg_en)));
  // R8: no event pending means no interrupt
  always_comb begin
    if (rst_n && flags == '0) a_r8_quiet: assert (!irq);
  end
endmodule

// File: rtl/poscmp_unit.sv
module poscmp_unit
  import poscmp_pkg::*;
#(
  parameter int unsigned PH_W = 16,
  parameter int unsigned Z_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_cnt,
  input  logic [Z_W-1:0]  z_cnt,
  input  logic            dir_neg,
  input  logic [PH_W-1:0] phase_cmp,
  input  logic [Z_W-1:0]  z_cmp,
  input  logic            z_cmp_dis,
  input  logic            dir_sel,
  input  logic            dir_ignore,
  input  logic            wdog_evt,
  input  logic            home_evt,
  input  logic            zidx_evt,
  input  logic            clr_wr,
  input  logic [3:0]      clr_mask,
  input  logic [3:0]      irq_en,
  input  logic [3:0]      trg_en,
  output logic [3:0]      flags,
  output logic            irq,
  output logic            trg
);
  logic           cmp_cond, cmp_hit;
  logic [NEV-1:0] evt_vec;

  poscmp_match #(.PH_W(PH_W), .Z_W(Z_W)) u_match (
    .clk, .rst_n, .phase_cnt, .z_cnt, .dir_neg, .phase_cmp, .z_cmp,
    .z_cmp_dis, .dir_sel, .dir_ignore, .cond(cmp_cond), .hit(cmp_hit)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[EV_WDOG] = wdog_evt;
    evt_vec[EV_HOME] = home_evt;
    evt_vec[EV_CMP]  = cmp_hit;
    evt_vec[EV_ZIDX] = zidx_evt;
  end

  poscmp_flags u_flags (
    .clk, .rst_n, .evt(evt_vec), .clr_wr, .clr_mask, .irq_en, .trg_en,
    .flags, .irq, .trg
  );

  // R2: a detected compare event shows up in the register next cycle
  a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flags[EV_CMP]);
  // R10: the watchdog pulse lands on bit 3
  a_r10_wdog_pos: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> flags[EV_WDOG]);
  // R2: bit 1 only rises after a detected match
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[EV_CMP]) |-> $past(cmp_hit));
endmodule

// File: tb/test_poscmp_unit.sv
module test_poscmp_unit;
  localparam int PH_W = 16;
  localparam int Z_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PH_W-1:0] phase_cnt = '0, phase_cmp = '0;
  logic [Z_W-1:0]  z_cnt = '0, z_cmp = '0;
  logic dir_neg = 0, z_cmp_dis = 0, dir_sel = 0, dir_ignore = 0;
  logic wdog_evt = 0, home_evt = 0, zidx_evt = 0, clr_wr = 0;
  logic [3:0] clr_mask = '0, irq_en = '0, trg_en = '0;
  logic [3:0] flags;
  logic irq, trg;

  always #4 clk = ~clk;

  poscmp_unit #(.PH_W(PH_W), .Z_W(Z_W)) i_poscmp_unit (
    .clk, .rst_n, .phase_cnt, .z_cnt, .dir_neg, .phase_cmp, .z_cmp,
    .z_cmp_dis, .dir_sel, .dir_ignore, .wdog_evt, .home_evt, .zidx_evt,
    .clr_wr, .clr_mask, .irq_en, .trg_en, .flags, .irq, .trg
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic       prev_c = 0;
  logic [3:0] m_flags = '0;
  logic       m_trg = 0;

  function automatic logic want_match();
    logic ok;
    ok = (phase_cnt == phase_cmp);
    if (!z_cmp_dis && z_cnt != z_cmp) ok = 0;
    if (!dir_ignore) begin
      if (dir_sel == 1'b0 && dir_neg) ok = 0;
      if (dir_sel == 1'b1 && !dir_neg) ok = 0;
    end
    return ok;
  endfunction

  function automatic logic want_irq(input logic [3:0] f);
    for (int i = 0; i < 4; i++) if (f[i] && irq_en[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag);
    logic e_irq;
    e_irq = want_irq(m_flags);
    n_chk++;
    if (flags !== m_flags || irq !== e_irq || trg !== m_trg) begin
      n_bad++;
      $display("FAIL %s: flags/irq/trg actual %b/%b/%b expected %b/%b/%b",
               tag, flags, irq, trg, m_flags, e_irq, m_trg);
    end
  endtask

  // one clock: predict, clock, compare
  task automatic step(input string tag);
    logic c, hit;
    logic [3:0] ev, nx;
    c   = want_match();
    hit = c && !prev_c;
    ev  = {wdog_evt, home_evt, hit, zidx_evt};
    nx  = m_flags;
    if (clr_wr) nx = nx & ~clr_mask;
    nx  = nx | ev;
    m_trg   = (ev & trg_en) != 0;
    m_flags = nx;
    prev_c  = c;
    @(posedge clk); #1;
    check(tag);
    clr_wr = 0; wdog_evt = 0; home_evt = 0; zidx_evt = 0;
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_mask = 4'hF; step("R6");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    phase_cmp = 16'd100; z_cmp = 16'd5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1");
    step("R1");

    // R2 basic match
    phase_cnt = 100; z_cnt = 5; step("R2");
    step("R5"); step("R5");
    clr_wr = 1; clr_mask = 4'b0010; step("R6");
    step("R5"); step("R5");
    // R7 set beats clear
    phase_cnt = 0; step("R7");
    phase_cnt = 100; clr_wr = 1; clr_mask = 4'b0010; step("R7");
    // R6 other bits do not touch bit 1
    clr_wr = 1; clr_mask = 4'b1101; step("R6");
    clear_all();
    // R3 revolution term
    phase_cnt = 0; step("R3");
    z_cnt = 9; phase_cnt = 100; step("R3");
    phase_cnt = 0; step("R3");
    z_cmp_dis = 1; phase_cnt = 100; step("R3");
    clear_all(); phase_cnt = 0; z_cmp_dis = 0; z_cnt = 5; step("R4");
    // R4 direction
    dir_sel = 1; dir_neg = 0; phase_cnt = 100; step("R4");
    phase_cnt = 0; step("R4");
    dir_neg = 1; phase_cnt = 100; step("R4");
    clear_all(); phase_cnt = 0; step("R4");
    dir_sel = 0; dir_neg = 1; dir_ignore = 1; phase_cnt = 100; step("R4");
    clear_all(); phase_cnt = 0; dir_ignore = 0; dir_neg = 0; step("R4");
    // R10 bit positions, R8 irq, R9 trigger
    wdog_evt = 1; step("R10");
    home_evt = 1; step("R10");
    zidx_evt = 1; step("R10");
    irq_en = 4'b0010; step("R8");
    irq_en = 4'b1000; step("R8");
    clr_wr = 1; clr_mask = 4'b1000; step("R8");
    clear_all();
    trg_en = 4'b0100; home_evt = 1; step("R9");
    step("R9");
    zidx_evt = 1; step("R9");
    trg_en = 4'b0010; phase_cnt = 100; step("R9");
    step("R9");
    clear_all();

    // constrained random, position kept near the target
    void'($urandom(32'd7331));
    for (int k = 0; k < 3000; k++) begin
      phase_cmp  = 16'($urandom_range(0, 7));
      phase_cnt  = ($urandom_range(0, 2) != 0) ? phase_cmp : phase_cmp + 16'd1;
      z_cmp      = 16'($urandom_range(0, 3));
      z_cnt      = ($urandom_range(0, 2) != 0) ? z_cmp : z_cmp ^ 16'd1;
      z_cmp_dis  = $urandom_range(0, 3) == 0;
      dir_sel    = $urandom_range(0, 1) == 1;
      dir_neg    = $urandom_range(0, 1) == 1;
      dir_ignore = $urandom_range(0, 3) == 0;
      wdog_evt   = $urandom_range(0, 15) == 0;
      home_evt   = $urandom_range(0, 15) == 0;
      zidx_evt   = $urandom_range(0, 15) == 0;
      clr_wr     = $urandom_range(0, 3) == 0;
      clr_mask   = 4'($urandom_range(0, 15));
      irq_en     = 4'($urandom_range(0, 15));
      trg_en     = 4'($urandom_range(0, 15));
      step("R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule